// File: doc/BRIEF.md
# Watchdog Timer with Timed Unlock and Refresh Sequences

This block is a watchdog counter on a byte-wide register bus, clocked by the bus clock. After software enables it, a 16-bit counter advances on ticks from a selectable source. The source is the bus clock itself, a slow low-power tick or an alternate tick. The two slow sources are synchronised into the bus domain. If the counter reaches the programmed timeout, the block raises a reset request. The request stays high until the next reset.

Software keeps the watchdog alive by writing a refresh sequence of two 16-bit words to the counter register. A different two-word unlock sequence clears the counter. When enabled during the first configuration, the unlock also reopens configuration for a short window. The control byte is write-once after reset. Configuration opens again only if the update-allowed bit was set in that first write. Per-mode enables decide whether the counter runs while the system is in debug, wait or stop mode. An optional windowed mode rejects refreshes that come too early.

Top module: `wdog_timer`

## Requirements
- R1: After reset, resetReq is 0, the control byte (address 0) and clock-select byte (address 1) read 0x00, the timeout reads 0xFFFF and the window reads 0x0000.
- R2: 16-bit registers are big-endian byte pairs with the high byte at the lower address: counter at 2/3, timeout at 4/5, window at 6/7. The clock-select byte keeps only bits [1:0]. The counter bytes read the live count, and writes to them do not load it.
- R3: A 16-bit word is formed when the low counter byte (address 3) is written, using the last value written to address 2. The word 0xC520 followed by 0xD928, with the second word no more than 16 bus clocks after the first, clears the counter to 0x0000.
- R4: The first write to the control byte after reset closes configuration. Later writes to any configuration register (addresses 0, 1, 4–7) are ignored until configuration is reopened.
- R5: If the update-allowed bit (control bit 5) was 1, a completed unlock reopens configuration. This allows reconfiguration, including clearing the enable bit (control bit 7). If the bit was 0, an unlock does not reopen configuration.
- R6: Configuration reopened by an unlock accepts writes for 128 bus clocks and is locked again afterwards.
- R7: The refresh sequence 0xA602 followed by 0xB480, second word within 16 bus clocks, clears the counter.
- R8: While enabled, a wrong second word, or a second word that is more than 16 bus clocks late, in either sequence raises resetReq at once. While disabled, no reset request is raised.
- R9: While enabled, the counter stops at the timeout value and resetReq is raised. resetReq then stays high until reset.
- R10: With windowed mode on (control bit 6), a refresh while the counter is below the window value raises resetReq. A refresh at or above the window value does not.
- R11: The counter holds while debug, wait or stop mode is active unless the matching enable is set (control bits 2, 1, 0).
- R12: Clock select 0 counts every bus clock. Clock select 1 counts rising edges of lpoTick after a two-flop synchroniser. Clock select 2 or 3 counts rising edges of altTick in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Byte write strobe |
| addr | input | 3 | Register byte address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr |
| lpoTick | input | 1 | Asynchronous low-power tick |
| altTick | input | 1 | Asynchronous alternate tick |
| dbgMode | input | 1 | System in debug mode |
| waitMode | input | 1 | System in wait mode |
| stopMode | input | 1 | System in stop mode |
| resetReq | output | 1 | Sticky reset request |

## Verification
The bench targets the sequence timing edges. A late second unlock word must raise a reset request, and an on-time one must clear the counter. A design with an off-by-some limit, or one that ignores late words, would either reset healthy software or let a runaway loop escape. It checks that the write-once control byte stays locked through an unlock when update was not allowed. It also checks that a reopened configuration closes after its window, since a design that leaks writes here lets errant code disable the watchdog. Early refreshes in windowed mode, the mode gates, and edge-only counting of the slow ticks are each probed with the counter frozen, so the expected value is exact.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_CLKSEL = 3'd1;
  localparam logic [2:0] A_CNT_HI = 3'd2;
  localparam logic [2:0] A_CNT_LO = 3'd3;
  localparam logic [2:0] A_TO_HI  = 3'd4;
  localparam logic [2:0] A_TO_LO  = 3'd5;
  localparam logic [2:0] A_WIN_HI = 3'd6;
  localparam logic [2:0] A_WIN_LO = 3'd7;

  localparam logic [CNT_W-1:0] UNLK_W1 = 16'hC520;
  localparam logic [CNT_W-1:0] UNLK_W2 = 16'hD928;
  localparam logic [CNT_W-1:0] RFSH_W1 = 16'hA602;
  localparam logic [CNT_W-1:0] RFSH_W2 = 16'hB480;

  typedef struct packed {
    logic clrCnt;
    logic seqViol;
    logic refreshDone;
  } wdStrobe_t;

  typedef struct packed {
    logic             en;
    logic             winEn;
    logic             upd;
    logic             dbgEn;
    logic             waitEn;
    logic             stopEn;
    logic [1:0]       clkSel;
    logic [CNT_W-1:0] toVal;
    logic [CNT_W-1:0] winVal;
  } wdCfg_t;
endpackage

// File: rtl/wdog_tick_sync.sv
module wdog_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic rise
);
  logic [STAGES:0] shReg;

  always_ff @(posedge clk) begin
    if (!rstN) shReg <= '0;
    else       shReg <= {shReg[STAGES-1:0], asyncIn};
  end

  assign rise = shReg[STAGES-1] & ~shReg[STAGES];
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int SEQ_LIM  = 16,
  parameter int OPEN_CYC = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [CNT_W-1:0] count,
  output logic [BYTE_W-1:0] rdData,
  output wdCfg_t           cfg,
  output wdStrobe_t        stb
);
  localparam int SEQ_CW  = $clog2(SEQ_LIM + 1);
  localparam int OPEN_CW = $clog2(OPEN_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_UNLK, S_RFSH} seqState_t;

  seqState_t           state, nextState;
  logic [SEQ_CW-1:0]   seqCnt;
  logic [OPEN_CW-1:0]  openCnt;
  logic [BYTE_W-1:0]   hiLatch;
  logic                firstPend;
  logic                cfgOpen;
  logic                wordStb;
  logic                unlockDone;
  logic                seqExpired;
  logic [CNT_W-1:0]    word;

  assign wordStb    = wrEn && (addr == A_CNT_LO);
  assign word       = {hiLatch, wrData};
  assign cfgOpen    = firstPend || (openCnt != '0);
  assign seqExpired = (seqCnt == SEQ_CW'(SEQ_LIM));

  always_comb begin
    nextState  = state;
    stb        = '0;
    unlockDone = 1'b0;
    unique case (state)
      S_IDLE: if (wordStb) begin
        if (word == UNLK_W1)      nextState = S_UNLK;
        else if (word == RFSH_W1) nextState = S_RFSH;
      end
      S_UNLK: begin
        if (wordStb) begin
          nextState = S_IDLE;
          if (word == UNLK_W2) begin
            stb.clrCnt = 1'b1;
            unlockDone = 1'b1;
          end else stb.seqViol = 1'b1;
        end else if (seqExpired) begin
          nextState   = S_IDLE;
          stb.seqViol = 1'b1;
        end
      end
      S_RFSH: begin
        if (wordStb) begin
          nextState = S_IDLE;
          if (word == RFSH_W2) begin
            stb.clrCnt      = 1'b1;
            stb.refreshDone = 1'b1;
          end else stb.seqViol = 1'b1;
        end else if (seqExpired) begin
          nextState   = S_IDLE;
          stb.seqViol = 1'b1;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      seqCnt  <= '0;
      hiLatch <= '0;
    end else begin
      state <= nextState;
      if (wrEn && addr == A_CNT_HI) hiLatch <= wrData;
      if (state == S_IDLE) seqCnt <= (nextState != S_IDLE) ? SEQ_CW'(1) : '0;
      else if (!seqExpired) seqCnt <= seqCnt + SEQ_CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) openCnt <= '0;
    else if (unlockDone && cfg.upd) openCnt <= OPEN_CW'(OPEN_CYC);
    else if (openCnt != '0) openCnt <= openCnt - OPEN_CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstPend <= 1'b1;
      cfg       <= '{en: 1'b0, winEn: 1'b0, upd: 1'b0, dbgEn: 1'b0, waitEn: 1'b0,
                     stopEn: 1'b0, clkSel: 2'd0, toVal: '1, winVal: '0};
    end else if (wrEn && cfgOpen) begin
      unique case (addr)
        A_CTRL: begin
          firstPend  <= 1'b0;
          cfg.en     <= wrData[7];
          cfg.winEn  <= wrData[6];
          cfg.upd    <= wrData[5];
          cfg.dbgEn  <= wrData[2];
          cfg.waitEn <= wrData[1];
          cfg.stopEn <= wrData[0];
        end
        A_CLKSEL: cfg.clkSel <= wrData[1:0];
        A_TO_HI:  cfg.toVal[CNT_W-1:BYTE_W]  <= wrData;
        A_TO_LO:  cfg.toVal[BYTE_W-1:0]      <= wrData;
        A_WIN_HI: cfg.winVal[CNT_W-1:BYTE_W] <= wrData;
        A_WIN_LO: cfg.winVal[BYTE_W-1:0]     <= wrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      A_CTRL:   rdData = {cfg.en, cfg.winEn, cfg.upd, 2'b00, cfg.dbgEn, cfg.waitEn, cfg.stopEn};
      A_CLKSEL: rdData = {6'd0, cfg.clkSel};
      A_CNT_HI: rdData = count[CNT_W-1:BYTE_W];
      A_CNT_LO: rdData = count[BYTE_W-1:0];
      A_TO_HI:  rdData = cfg.toVal[CNT_W-1:BYTE_W];
      A_TO_LO:  rdData = cfg.toVal[BYTE_W-1:0];
      A_WIN_HI: rdData = cfg.winVal[CNT_W-1:BYTE_W];
      default:  rdData = cfg.winVal[BYTE_W-1:0];
    endcase
  end

  // R3 R7 R8
  seq_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> (seqCnt <= SEQ_CW'(SEQ_LIM)));

  // R4
  ctrl_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_CTRL && !cfgOpen) |=>
      $stable({cfg.en, cfg.winEn, cfg.upd, cfg.dbgEn, cfg.waitEn, cfg.stopEn}));

  // R6
  open_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    openCnt <= OPEN_CW'(OPEN_CYC));
endmodule

// File: rtl/wdog_data.sv
module wdog_data
  import wdog_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int N_SRC       = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdCfg_t           cfg,
  input  wdStrobe_t        stb,
  input  logic [N_SRC-1:0] slowTick,
  input  logic             dbgMode,
  input  logic             waitMode,
  input  logic             stopMode,
  output logic [CNT_W-1:0] count,
  output logic             resetReq
);
  logic [N_SRC-1:0] tickRise;
  logic             tickSel;
  logic             modeOk;
  logic             run;
  logic             hit;
  logic             earlyRefresh;

  for (genvar i = 0; i < N_SRC; i++) begin : g_sync
    wdog_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rstN(rstN), .asyncIn(slowTick[i]), .rise(tickRise[i])
    );
  end

  always_comb begin
    unique case (cfg.clkSel)
      2'd0:    tickSel = 1'b1;
      2'd1:    tickSel = tickRise[0];
      default: tickSel = tickRise[N_SRC-1];
    endcase
  end

  assign modeOk = !(dbgMode && !cfg.dbgEn) && !(waitMode && !cfg.waitEn)
               && !(stopMode && !cfg.stopEn);
  assign run          = cfg.en && modeOk && tickSel;
  assign hit          = cfg.en && (count == cfg.toVal);
  assign earlyRefresh = stb.refreshDone && cfg.winEn && (count < cfg.winVal);

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else if (stb.clrCnt) count <= '0;
    else if (run && count != cfg.toVal) count <= count + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) resetReq <= 1'b0;
    else if (cfg.en && (stb.seqViol || hit || earlyRefresh)) resetReq <= 1'b1;
  end

  // R9
  sticky_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> resetReq);

  // R3
  clear_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrCnt |=> (count == '0));

  // R11
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopMode && !cfg.stopEn && !stb.clrCnt) |=> $stable(count));

  // R9
  timeout_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.en && count == cfg.toVal) |=> resetReq);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int SEQ_LIM     = 16,
  parameter int OPEN_CYC    = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       lpoTick,
  input  logic       altTick,
  input  logic       dbgMode,
  input  logic       waitMode,
  input  logic       stopMode,
  output logic       resetReq
);
  wdCfg_t           cfg;
  wdStrobe_t        stb;
  logic [CNT_W-1:0] count;

  wdog_ctrl #(.SEQ_LIM(SEQ_LIM), .OPEN_CYC(OPEN_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .count(count), .rdData(rdData), .cfg(cfg), .stb(stb)
  );

  wdog_data #(.SYNC_STAGES(SYNC_STAGES), .N_SRC(2)) u_data (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb),
    .slowTick({altTick, lpoTick}), .dbgMode(dbgMode), .waitMode(waitMode),
    .stopMode(stopMode), .count(count), .resetReq(resetReq)
  );
endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       lpoTick = 1'b0, altTick = 1'b0;
  logic       dbgMode = 1'b0, waitMode = 1'b0, stopMode = 1'b0;
  logic       resetReq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdog_timer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .lpoTick(lpoTick), .altTick(altTick), .dbgMode(dbgMode),
    .waitMode(waitMode), .stopMode(stopMode), .resetReq(resetReq)
  );

  // {addr, write data, expected readback} during first configuration
  localparam logic [18:0] VEC [0:6] = '{
    {3'd1, 8'h02, 8'h02}, {3'd1, 8'h07, 8'h03}, {3'd4, 8'h12, 8'h12},
    {3'd5, 8'h34, 8'h34}, {3'd6, 8'hAB, 8'hAB}, {3'd7, 8'hCD, 8'hCD},
    {3'd2, 8'h5A, 8'h00}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); wrEn = 1'b0; addr = a; #1; d = rdData;
  endtask

  task automatic word(input logic [15:0] w);
    wr(3'd2, w[15:8]); wr(3'd3, w[7:0]);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; wrEn = 1'b0;
    lpoTick = 0; altTick = 0; dbgMode = 0; waitMode = 0; stopMode = 0;
    cyc(3); rstN = 1'b1; cyc(1);
  endtask

  task automatic pulse(input bit useAlt, input int n);
    for (int i = 0; i < n; i++) begin
      if (useAlt) altTick = 1'b1; else lpoTick = 1'b1;
      cyc(6);
      if (useAlt) altTick = 1'b0; else lpoTick = 1'b0;
      cyc(6);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    doReset();
    // R1 reset state
    chk("R1 resetReq", resetReq, 0);
    rd(3'd0, d); chk("R1 ctrl", d, 8'h00);
    rd(3'd1, d); chk("R1 clksel", d, 8'h00);
    rd(3'd4, d); chk("R1 toHi", d, 8'hFF);
    rd(3'd5, d); chk("R1 toLo", d, 8'hFF);
    rd(3'd7, d); chk("R1 winLo", d, 8'h00);

    // R2 table of writes and readbacks
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], d);
      chk("R2 table", d, VEC[i][7:0]);
    end

    // R4 write-once, R5 no update allowed
    doReset();
    wr(3'd0, 8'h80);
    wr(3'd0, 8'h00); rd(3'd0, d); chk("R4 ctrl relock", d, 8'h80);
    wr(3'd5, 8'h11); rd(3'd5, d); chk("R4 toLo ignored", d, 8'hFF);
    word(16'hC520); word(16'hD928);
    wr(3'd0, 8'h00); rd(3'd0, d); chk("R5 no reopen", d, 8'h80);
    chk("R5 no reset", resetReq, 0);

    // R3 unlock clears, R5 reopen, R6 window closes
    doReset();
    wr(3'd0, 8'hA0); cyc(40); stopMode = 1'b1; cyc(2);
    rd(3'd3, d); chk("R11 stop frozen nonzero", (d >= 8'd30) ? 1 : 0, 1);
    word(16'hC520); word(16'hD928);
    rd(3'd2, d); rd(3'd3, d2); chk("R3 unlock clears", {d, d2}, 16'h0000);
    wr(3'd0, 8'h20); rd(3'd0, d); chk("R5 reconfig disable", d, 8'h20);
    wr(3'd5, 8'h77); rd(3'd5, d); chk("R6 inside window", d, 8'h77);
    cyc(140);
    wr(3'd5, 8'h55); rd(3'd5, d); chk("R6 after window", d, 8'h77);

    // R8 late unlock word
    doReset();
    wr(3'd0, 8'h80);
    word(16'hC520); cyc(20); chk("R8 late unlock", resetReq, 1);
    // R8 wrong refresh word
    doReset();
    wr(3'd0, 8'h80);
    word(16'hA602); word(16'h1234); chk("R8 wrong word", resetReq, 1);
    // R8 disabled: no request
    doReset();
    word(16'hA602); word(16'h1234); cyc(2); chk("R8 disabled", resetReq, 0);

    // R9 timeout
    doReset();
    wr(3'd4, 8'h00); wr(3'd5, 8'd20); wr(3'd0, 8'h80);
    cyc(15); chk("R9 before timeout", resetReq, 0);
    cyc(10); chk("R9 at timeout", resetReq, 1);
    cyc(20); chk("R9 sticky", resetReq, 1);

    // R7 refresh keeps alive
    doReset();
    wr(3'd4, 8'h00); wr(3'd5, 8'd40); wr(3'd0, 8'h80);
    for (int i = 0; i < 6; i++) begin
      cyc(20); word(16'hA602); word(16'hB480);
    end
    chk("R7 refresh alive", resetReq, 0);
    cyc(50); chk("R9 after refresh stops", resetReq, 1);

    // R10 windowed refresh
    doReset();
    wr(3'd4, 8'h03); wr(3'd5, 8'hE8); wr(3'd7, 8'd100); wr(3'd0, 8'hC0);
    cyc(10); word(16'hA602); word(16'hB480); cyc(1);
    chk("R10 early refresh", resetReq, 1);
    doReset();
    wr(3'd4, 8'h03); wr(3'd5, 8'hE8); wr(3'd7, 8'd100); wr(3'd0, 8'hC0);
    cyc(120); word(16'hA602); word(16'hB480); cyc(1);
    chk("R10 late refresh ok", resetReq, 0);

    // R11 mode gating
    doReset();
    dbgMode = 1'b1; wr(3'd0, 8'h80); cyc(20);
    rd(3'd3, d); chk("R11 dbg hold", d, 8'h00);
    doReset();
    dbgMode = 1'b1; wr(3'd0, 8'h84); cyc(20);
    rd(3'd3, d); chk("R11 dbg run", (d > 0) ? 1 : 0, 1);
    doReset();
    waitMode = 1'b1; wr(3'd0, 8'h80); cyc(20);
    rd(3'd3, d); chk("R11 wait hold", d, 8'h00);

    // R12 clock selects
    doReset();
    wr(3'd1, 8'h01); wr(3'd0, 8'h80);
    pulse(1'b0, 5); cyc(4);
    rd(3'd3, d); chk("R12 lpo edges", d, 8'd5);
    pulse(1'b1, 2); rd(3'd3, d); chk("R12 alt ignored", d, 8'd5);
    doReset();
    wr(3'd1, 8'h02); wr(3'd0, 8'h80);
    pulse(1'b1, 3); pulse(1'b0, 4); cyc(4);
    rd(3'd3, d); chk("R12 alt edges", d, 8'd3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule